// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution stage of a small datapath. Each accepted operation takes two operands, an operation code, an operand-width select and the incoming carry flag. It produces a result and six condition bits. The bits cover unsigned carry or borrow, even parity of the low byte, a nibble carry out of bit 3, zero, sign and signed overflow. All of them are evaluated at the selected width of 8, 16 or 32 bits.

The arithmetic operations are add, add-with-carry, subtract, subtract-with-borrow, compare, increment, decrement and negate. Bitwise AND, OR and XOR complete the set. Add-with-carry and subtract-with-borrow fold the incoming carry into the operation, which lets wider numbers be built from a chain of word operations. Increment and decrement step a counter without disturbing the carry chain: the carry output repeats the incoming carry.

Compare sets the condition bits exactly as a subtraction would, and it does not update the result. The result, the flags and a write strobe are registered. They appear one clock after the operation is presented, together with a one-cycle valid pulse.

Top module: `int_alu_core`

## Requirements
- R1: While reset is active, and until the first accepted operation, `out_valid` is 0, `res_we` is 0, `res_o` is 0 and `flags_o` is 0. Reset is asynchronous active-low, and its release passes through a two-flop synchronizer.
- R2: An operation presented with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for that one cycle. With `in_valid` low, `out_valid` is 0 and `res_o`, `res_we` and `flags_o` keep their values.
- R3: `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the selected width are ignored, and result bits above it are driven to 0.
- R4: Op 0 (add) gives a+b and op 1 (add-with-carry) gives a+b+carry_in, both at the selected width. The carry flag (`flags_o[0]`) is the carry out of the width's top bit.
- R5: Op 2 (subtract) gives a-b and op 3 (subtract-with-borrow) gives a-b-carry_in. The carry flag is set on a borrow out of the top bit.
- R6: Op 5 (increment) gives a+1 and op 6 (decrement) gives a-1. The other five flags are updated, and the carry flag equals `carry_in`.
- R7: Op 4 (compare) sets all six flags as subtraction a-b does. `res_we` is 0 and `res_o` keeps its previous value. For example, comparing 254 with 17 at 8 bits gives carry 0, overflow 0, sign 1 and zero 0.
- R8: Op 7 (negate) gives 0-a. Carry is set exactly when the operand is not zero at the selected width.
- R9: Ops 8, 9 and 10 give AND, OR and XOR. Carry, overflow and adjust are 0, while zero, sign and parity follow the result.
- R10: The parity flag (`flags_o[1]`) is 1 when bits 7:0 of the result hold an even number of ones, whatever the width.
- R11: The adjust flag (`flags_o[2]`) is set on a carry or borrow out of bit 3.
- R12: The zero flag (`flags_o[3]`) is set when the result at the width is 0, and the sign flag (`flags_o[4]`) is its top bit. The overflow flag (`flags_o[5]`) is set when the two's-complement result does not fit the width.
- R13: Op codes 11 to 15 are reserved. They give `res_we` 0 and all flags 0, and they leave `res_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code |
| size | input | 2 | Operand width select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| carry_in | input | 1 | Incoming carry flag |
| res_o | output | 32 | Registered result, zero above the width |
| res_we | output | 1 | Result is to be written back |
| flags_o | output | 6 | {overflow, sign, zero, adjust, parity, carry} |
| out_valid | output | 1 | One-cycle pulse with each registered output |

## Verification
The operand pairs are chosen so that each one separates two flags that a wrong design could confuse.
- An 8-bit all-ones plus one raises carry, adjust, zero and parity together.
- The most positive value plus one raises overflow but not carry.
- Borrow cases separate subtraction from addition.
- Increment and decrement are run with both values of the incoming carry. This shows that carry is passed through rather than computed.
- Operands carry garbage above the selected width. Results whose low byte and full word differ in parity check the width handling.
- Compare, reserved codes and idle cycles are each followed by a look at the held result. This makes a stray write visible.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned NUM_SZ  = 3;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned NFLAGS  = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NEG = 4'd7,
    OP_AND = 4'd8,
    OP_OR  = 4'd9,
    OP_XOR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } alu_size_e;

  typedef enum logic [1:0] {
    K_ARITH = 2'd0,
    K_LOGIC = 2'd1,
    K_NONE  = 2'd2
  } alu_kind_e;

  // bit 0 carry ... bit 5 overflow
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         cf,
  output logic         af,
  output logic         ovf
);

  logic [W-1:0] bx;
  logic [W:0]   full;
  logic [W-1:0] low;
  logic [W-1:0] nib_x;
  logic         c_top;
  logic         c_msb;

  always_comb begin
    bx    = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    low   = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
    c_msb = low[W-1];
    c_top = full[W];
    sum   = full[W-1:0];
    nib_x = a ^ bx ^ full[W-1:0];
    // a borrow is the inverted carry of the complemented addend
    cf    = c_top ^ sub;
    af    = nib_x[4] ^ sub;
    ovf   = c_msb ^ c_top;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      default: y = a ^ b;
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  logic [DW-1:0]  raw,
  input  logic [1:0]     size,
  input  alu_kind_e      kind,
  input  logic           cf_arith,
  input  logic           af_arith,
  input  logic           of_arith,
  input  logic           keep_cf,
  input  logic           cf_prev,
  output logic [DW-1:0]  res,
  output alu_flags_t     flags
);

  logic [DW-1:0] mask;
  logic          top_bit;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin mask = DW'(8'hFF);    top_bit = raw[7];    end
      SZ_HALF: begin mask = DW'(16'hFFFF); top_bit = raw[15];   end
      default: begin mask = '1;            top_bit = raw[DW-1]; end
    endcase
  end

  always_comb begin
    flags = '0;
    res   = '0;
    if (kind != K_NONE) begin
      res      = raw & mask;
      flags.zf = (res == '0);
      flags.sf = top_bit;
      flags.pf = ~^res[7:0];
      if (kind == K_ARITH) begin
        flags.cf = keep_cf ? cf_prev : cf_arith;
        flags.af = af_arith;
        flags.of = of_arith;
      end
    end
  end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [1:0]        size,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic              carry_in,
  output logic [DW-1:0]     res_o,
  output logic              res_we,
  output logic [NFLAGS-1:0] flags_o,
  output logic              out_valid
);

  localparam int unsigned SZ_IDX_W = $clog2(NUM_SZ);

  // reset synchronizer: assert at once, release after two edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // operand steering
  alu_op_e       op_e;
  logic [DW-1:0] src_a, src_b;
  logic          do_sub, add_ci, keep_cf, wr_d;
  alu_kind_e     kind;
  logic [1:0]    lsel;

  assign op_e = alu_op_e'(op);

  always_comb begin
    src_a   = opa;
    src_b   = opb;
    do_sub  = 1'b0;
    add_ci  = 1'b0;
    keep_cf = 1'b0;
    wr_d    = 1'b1;
    kind    = K_ARITH;
    lsel    = 2'd0;
    unique case (op_e)
      OP_ADD: ;
      OP_ADC: add_ci = carry_in;
      OP_SUB: begin do_sub = 1'b1; add_ci = 1'b1; end
      OP_SBB: begin do_sub = 1'b1; add_ci = ~carry_in; end
      OP_CMP: begin do_sub = 1'b1; add_ci = 1'b1; wr_d = 1'b0; end
      OP_INC: begin src_b = DW'(1); keep_cf = 1'b1; end
      OP_DEC: begin src_b = DW'(1); do_sub = 1'b1; add_ci = 1'b1; keep_cf = 1'b1; end
      OP_NEG: begin src_a = '0; src_b = opa; do_sub = 1'b1; add_ci = 1'b1; end
      OP_AND: begin kind = K_LOGIC; lsel = 2'd0; end
      OP_OR:  begin kind = K_LOGIC; lsel = 2'd1; end
      OP_XOR: begin kind = K_LOGIC; lsel = 2'd2; end
      default: begin kind = K_NONE; wr_d = 1'b0; end
    endcase
  end

  // one adder per width
  logic [DW-1:0] sum_w [NUM_SZ];
  logic          cf_w  [NUM_SZ];
  logic          af_w  [NUM_SZ];
  logic          of_w  [NUM_SZ];

  for (genvar gi = 0; gi < NUM_SZ; gi++) begin : g_width
    localparam int unsigned W = 8 << gi;
    logic [W-1:0] s;
    alu_addsub #(.W(W)) u_addsub (
      .a   (src_a[W-1:0]),
      .b   (src_b[W-1:0]),
      .sub (do_sub),
      .ci  (add_ci),
      .sum (s),
      .cf  (cf_w[gi]),
      .af  (af_w[gi]),
      .ovf (of_w[gi])
    );
    assign sum_w[gi] = DW'(s);
  end

  logic [SZ_IDX_W-1:0] sz_idx;
  assign sz_idx = (size == 2'd3) ? SZ_IDX_W'(2) : SZ_IDX_W'(size);

  logic [DW-1:0] logic_y;
  alu_logic #(.DW(DW)) u_logic (
    .a   (opa),
    .b   (opb),
    .sel (lsel),
    .y   (logic_y)
  );

  logic [DW-1:0] raw;
  assign raw = (kind == K_LOGIC) ? logic_y : sum_w[sz_idx];

  logic [DW-1:0] res_d;
  alu_flags_t    flags_d;

  alu_flag_gen #(.DW(DW)) u_flags (
    .raw      (raw),
    .size     (size),
    .kind     (kind),
    .cf_arith (cf_w[sz_idx]),
    .af_arith (af_w[sz_idx]),
    .of_arith (of_w[sz_idx]),
    .keep_cf  (keep_cf),
    .cf_prev  (carry_in),
    .res      (res_d),
    .flags    (flags_d)
  );

  // next state
  logic [DW-1:0] res_q, res_nxt;
  alu_flags_t    flags_q, flags_nxt;
  logic          we_q, we_nxt, vld_q;

  always_comb begin
    res_nxt   = res_q;
    flags_nxt = flags_q;
    we_nxt    = we_q;
    if (in_valid) begin
      flags_nxt = flags_d;
      we_nxt    = wr_d;
      if (wr_d) res_nxt = res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q   <= '0;
      flags_q <= '0;
      we_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      res_q   <= res_nxt;
      flags_q <= flags_nxt;
      we_q    <= we_nxt;
      vld_q   <= in_valid;
    end
  end

  assign res_o     = res_q;
  assign res_we    = we_q;
  assign flags_o   = flags_q;
  assign out_valid = vld_q;

  // checks on the registered outputs
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_e == OP_CMP) |=> (!res_we && $stable(res_o))); // R7

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op_e == OP_INC || op_e == OP_DEC)) |=> (flags_o[0] == $past(carry_in))); // R6

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && size == SZ_BYTE && op <= OP_XOR && op_e != OP_CMP) |=> (res_o[DW-1:8] == '0)); // R3

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op >= OP_AND && op <= OP_XOR) |=> (!flags_o[0] && !flags_o[5] && !flags_o[2])); // R9

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> !(flags_o[3] && flags_o[4])); // R12

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op > OP_XOR) |=> (flags_o == '0 && !res_we)); // R13

endmodule

// File: tb/tb_int_alu_core.sv
module tb_int_alu_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [31:0] opa, opb;
  logic        carry_in;
  logic [31:0] res_o;
  logic        res_we;
  logic [5:0]  flags_o;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] held_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .opa(opa), .opb(opb), .carry_in(carry_in), .res_o(res_o), .res_we(res_we),
    .flags_o(flags_o), .out_valid(out_valid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model: flags packed {of,sf,zf,af,pf,cf}
  function automatic void model(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] a,
                                input logic [31:0] b, input logic ci, output logic [31:0] r,
                                output logic [5:0] f, output logic we);
    int w;
    logic [63:0] m, x, y, c, full;
    logic cf, af, of, zf, sf, pf, sx, sy, sr;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    x = 64'(a) & m; y = 64'(b) & m; c = 64'(ci);
    cf = 0; af = 0; of = 0; full = 0;
    we = (o <= 4'd10) && (o != 4'd4);
    if (o > 4'd10) begin
      r = 32'h0; f = 6'h0; return;
    end
    case (o)
      4'd0, 4'd1, 4'd5: begin
        if (o == 4'd5) y = 64'd1;
        if (o != 4'd1) c = 0;
        full = x + y + c;
        cf = full[w];
      end
      4'd2, 4'd3, 4'd4, 4'd6, 4'd7: begin
        if (o == 4'd7) begin y = x; x = 0; end
        if (o == 4'd6) y = 64'd1;
        if (o != 4'd3) c = 0;
        full = x - y - c;
        cf = (x < y + c);
      end
      4'd8: full = x & y;
      4'd9: full = x | y;
      default: full = x ^ y;
    endcase
    full = full & m;
    r = full[31:0];
    if (o <= 4'd7) begin
      sx = x[w-1]; sy = y[w-1]; sr = full[w-1];
      af = x[4] ^ y[4] ^ full[4];
      if (o == 4'd0 || o == 4'd1 || o == 4'd5) of = (sx == sy) && (sr != sx);
      else                                     of = (sx != sy) && (sr != sx);
      if (o == 4'd5 || o == 4'd6) cf = ci;
    end
    zf = (full == 0);
    sf = full[w-1];
    pf = ~^full[7:0];
    f = {of, sf, zf, af, pf, cf};
  endfunction

  task automatic run_op(input string req, input logic [3:0] o, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] b, input logic ci);
    logic [31:0] er; logic [5:0] ef; logic ew;
    model(o, sz, a, b, ci, er, ef, ew);
    @(negedge clk);
    in_valid = 1; op = o; size = sz; opa = a; opb = b; carry_in = ci;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk(req, "res_we", 32'(res_we), 32'(ew));
    chk(req, "result", res_o, ew ? er : held_res);
    chk(req, "flags", 32'(flags_o), 32'(ef));
    if (ew) held_res = er;
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "res_we", 32'(res_we), 0);
    chk("R1", "result", res_o, 0);
    chk("R1", "flags", 32'(flags_o), 0);
  endtask

  task automatic t_add();
    run_op("R4", 4'd0, 2'd0, 32'hFF, 32'h01, 0);      // carry, zero, adjust, parity
    chk("R11", "adjust", 32'(flags_o[2]), 1);
    run_op("R12", 4'd0, 2'd2, 32'h7FFFFFFF, 32'h1, 0);
    chk("R12", "overflow", 32'(flags_o[5]), 1);
    run_op("R4", 4'd1, 2'd1, 32'hFFFF, 32'h0, 1);
    chk("R4", "adc carry", 32'(flags_o[0]), 1);
    run_op("R3", 4'd0, 2'd0, 32'h12345680, 32'hAB000080, 0);
    chk("R3", "upper bits", res_o & 32'hFFFFFF00, 0);
    run_op("R3", 4'd0, 2'd3, 32'hFFFFFFFF, 32'h2, 0);
  endtask

  task automatic t_sub();
    run_op("R11", 4'd2, 2'd0, 32'h10, 32'h01, 0);
    run_op("R5", 4'd3, 2'd2, 32'h0, 32'h0, 1);
    chk("R5", "borrow", 32'(flags_o[0]), 1);
    run_op("R12", 4'd2, 2'd1, 32'h8000, 32'h1, 0);
    run_op("R5", 4'd3, 2'd0, 32'h50, 32'h20, 0);
  endtask

  task automatic t_cmp();
    run_op("R4", 4'd0, 2'd2, 32'h0000BEEF, 32'h0, 0);
    run_op("R7", 4'd4, 2'd0, 32'd254, 32'd17, 1);
    chk("R7", "cmp flags c/o/s/z", 32'({flags_o[0], flags_o[5], flags_o[4], flags_o[3]}), 32'b0010);
    chk("R7", "result kept", res_o, 32'h0000BEEF);
  endtask

  task automatic t_incdec();
    run_op("R6", 4'd5, 2'd0, 32'hFF, 32'h0, 0);
    run_op("R6", 4'd5, 2'd0, 32'hFF, 32'h0, 1);
    run_op("R6", 4'd6, 2'd0, 32'h80, 32'h0, 1);
    run_op("R6", 4'd6, 2'd0, 32'h00, 32'h0, 0);
    run_op("R6", 4'd5, 2'd1, 32'h7FFF, 32'h0, 1);
  endtask

  task automatic t_neg();
    run_op("R8", 4'd7, 2'd0, 32'hFFFFFF00, 32'h0, 1);
    chk("R8", "zero operand no carry", 32'(flags_o[0]), 0);
    run_op("R8", 4'd7, 2'd2, 32'h5, 32'h0, 0);
    chk("R8", "carry", 32'(flags_o[0]), 1);
    run_op("R8", 4'd7, 2'd0, 32'h80, 32'h0, 0);
  endtask

  task automatic t_logic();
    run_op("R9", 4'd8, 2'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 1);
    run_op("R9", 4'd9, 2'd1, 32'h8000, 32'h0001, 1);
    run_op("R9", 4'd10, 2'd0, 32'hAA, 32'hAA, 1);
  endtask

  task automatic t_parity();
    run_op("R10", 4'd10, 2'd2, 32'hFF000000, 32'h00000001, 0);
    chk("R10", "low byte odd", 32'(flags_o[1]), 0);
    run_op("R10", 4'd9, 2'd2, 32'h00010000, 32'h00000003, 0);
    chk("R10", "low byte even", 32'(flags_o[1]), 1);
  endtask

  task automatic t_hold();
    logic [31:0] r0; logic [5:0] f0; logic w0;
    r0 = res_o; f0 = flags_o; w0 = res_we;
    @(negedge clk);
    op = 4'd0; opa = 32'h1234; opb = 32'h4321; carry_in = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    chk("R2", "idle valid", 32'(out_valid), 0);
    chk("R2", "idle result", res_o, r0);
    chk("R2", "idle flags", 32'(flags_o), 32'(f0));
    chk("R2", "idle we", 32'(res_we), 32'(w0));
  endtask

  task automatic t_reserved();
    run_op("R13", 4'd12, 2'd2, 32'h1, 32'h1, 1);
    run_op("R13", 4'd15, 2'd0, 32'hFF, 32'h0, 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; op = 0; size = 0; opa = 0; opb = 0; carry_in = 0;
    held_res = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_incdec();
    t_neg();
    t_logic();
    t_parity();
    t_hold();
    t_reserved();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule